// File: doc/BRIEF.md
# HDLC Transmit Byte Queue with Packet Length Tagger

This block sits between a host and an HDLC transmit framer. The host pushes data bytes into a 32-entry queue. A downstream framer pops them, and each popped byte comes with a one-bit end-of-packet mark. The host does not mark packet ends by hand. It programs a 7-bit packet length, and a down-counter that decrements on every accepted byte sets the mark on the byte that completes the packet. When the repeat control is set, the counter reloads the programmed length after each marked byte. Long streams of equal-length packets then need only one length write.

The host sees a 2-bit fill code built around a fixed 16-byte threshold, the live counter value, and two sticky error flags. One flag records writes that were dropped because the queue was full. The other records reads that were attempted while the queue was empty. Flag insertion, zero-bit insertion, CRC and serialization belong to the framer downstream.

The counter is a three-state machine. The states are IDLE (count is zero, nothing will be marked), COUNTING (count above one) and LAST (count is one, the next accepted byte is marked). The transitions are:
- LOAD: a length write moves the machine from any state to the state that matches the new length.
- STEP: an accepted byte in COUNTING decrements the count. The machine moves to LAST when the count reaches one.
- WRAP: a marked byte in LAST with repeat set reloads the programmed length.
- STOP: a marked byte in LAST with repeat clear returns the machine to IDLE.

Top module: `hdlc_txq_top`

## Requirements
- R1: After a synchronous reset, fill_code is 2'b10, ctr_val is 0, and ovf_flag and udf_flag are 0.
- R2: A cycle with len_wr high makes ctr_val equal len_val after that clock edge. The value is also stored as the programmed length.
- R3: Each accepted write (wr_en high while not full) decrements a ctr_val above 1 by one at that clock edge.
- R4: An accepted write while ctr_val is 1 is stored with its end-of-packet bit set. Every other write is stored with that bit clear.
- R5: With cyc_en high, the marked write reloads ctr_val with the programmed length.
- R6: With cyc_en low, the marked write leaves ctr_val at 0. ctr_val then stays at 0 and no byte is marked until the next len_wr.
- R7: Bytes leave in write order. A read accepted at a clock edge shows its byte on rd_data and its mark on rd_eop after that edge.
- R8: fill_code gives 2'b10 for 0 entries, 2'b11 for 1 to 15 entries, 2'b01 for 16 to 31 entries and 2'b00 for 32 entries.
- R9: A write while full is dropped and does not change ctr_val. It sets ovf_flag, which stays set until reset.
- R10: A read while empty leaves rd_data and rd_eop unchanged. It sets udf_flag, which stays set until reset.
- R11: When len_wr and an accepted write fall in the same cycle, the mark for that write follows the old count, and ctr_val takes len_val.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| len_wr | input | 1 | Load strobe for the packet length |
| len_val | input | 7 | Packet length in bytes |
| cyc_en | input | 1 | Repeat: reload the length after each marked byte |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 8 | Host write byte |
| rd_en | input | 1 | Framer read strobe |
| rd_data | output | 8 | Last byte popped |
| rd_eop | output | 1 | End-of-packet mark of the last byte popped |
| fill_code | output | 2 | Fill status code |
| ctr_val | output | 7 | Current packet byte counter |
| ovf_flag | output | 1 | Sticky dropped-write flag |
| udf_flag | output | 1 | Sticky empty-read flag |

## Verification
Every result is due one clock edge after its stimulus. This applies to ctr_val after a write or a length load, to rd_data and rd_eop after a read, to fill_code after any change in occupancy, and to the sticky flags after a dropped access. The bench drives all inputs on the falling edge and samples the outputs on the next falling edge, half a period after the edge that registered them. A monitor arms itself on each rising edge that carries an accepted read. It then compares the popped byte with the head of a scoreboard queue. The write driver fills that queue with marks taken from the bench's own model of the length counter.

// File: rtl/hdlc_txq_pkg.sv
package hdlc_txq_pkg;

    typedef enum logic [1:0] {
        CS_IDLE     = 2'd0,
        CS_COUNTING = 2'd1,
        CS_LAST     = 2'd2
    } ctr_state_e;

    typedef enum logic [1:0] {
        FILL_FULL  = 2'b00,
        FILL_HIGH  = 2'b01,
        FILL_EMPTY = 2'b10,
        FILL_LOW   = 2'b11
    } fill_code_e;

endpackage

// File: rtl/hdlc_txq_lenctr.sv
module hdlc_txq_lenctr
    import hdlc_txq_pkg::*;
#(
    parameter int CTR_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CTR_W-1:0] load_val,
    input  logic             cyc_en,
    input  logic             push_ok,
    output logic [CTR_W-1:0] count,
    output logic             tag
);

    localparam logic [CTR_W-1:0] ONE = CTR_W'(1);

    ctr_state_e       state_q, state_d;
    logic [CTR_W-1:0] count_q, count_d;
    logic [CTR_W-1:0] prog_q;

    function automatic ctr_state_e state_of(input logic [CTR_W-1:0] v);
        if (v == '0)
            return CS_IDLE;
        else if (v == ONE)
            return CS_LAST;
        else
            return CS_COUNTING;
    endfunction

    // next state and next count
    always_comb begin
        state_d = state_q;
        count_d = count_q;
        if (load) begin
            count_d = load_val;                   // LOAD
            state_d = state_of(load_val);
        end else if (push_ok) begin
            unique case (state_q)
                CS_IDLE: begin
                    state_d = CS_IDLE;
                    count_d = '0;
                end
                CS_COUNTING: begin
                    count_d = count_q - ONE;      // STEP
                    state_d = state_of(count_q - ONE);
                end
                CS_LAST: begin
                    if (cyc_en) begin
                        count_d = prog_q;         // WRAP
                        state_d = state_of(prog_q);
                    end else begin
                        count_d = '0;             // STOP
                        state_d = CS_IDLE;
                    end
                end
                default: begin
                    state_d = CS_IDLE;
                    count_d = '0;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= CS_IDLE;
            count_q <= '0;
            prog_q  <= '0;
        end else begin
            state_q <= state_d;
            count_q <= count_d;
            if (load)
                prog_q <= load_val;
        end
    end

    // outputs
    always_comb begin
        count = count_q;
        tag   = (state_q == CS_LAST);
    end

endmodule

// File: rtl/hdlc_txq_store.sv
module hdlc_txq_store #(
    parameter int WIDTH = 9,
    parameter int DEPTH = 32
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       push,
    input  logic [WIDTH-1:0]           din,
    input  logic                       pop,
    output logic [WIDTH-1:0]           dout,
    output logic [$clog2(DEPTH+1)-1:0] level
);

    localparam int PTR_W = $clog2(DEPTH);
    localparam int LVL_W = $clog2(DEPTH+1);
    localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);

    logic [WIDTH-1:0] mem_q [DEPTH];
    logic [PTR_W-1:0] wptr_q, rptr_q;
    logic [LVL_W-1:0] level_q;
    logic [WIDTH-1:0] dout_q;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == LAST_IDX) ? '0 : p + PTR_W'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (push)
            mem_q[wptr_q] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr_q  <= '0;
            rptr_q  <= '0;
            level_q <= '0;
            dout_q  <= '0;
        end else begin
            if (push)
                wptr_q <= bump(wptr_q);
            if (pop) begin
                rptr_q <= bump(rptr_q);
                dout_q <= mem_q[rptr_q];
            end
            unique case ({push, pop})
                2'b10:   level_q <= level_q + LVL_W'(1);
                2'b01:   level_q <= level_q - LVL_W'(1);
                default: level_q <= level_q;
            endcase
        end
    end

    assign dout  = dout_q;
    assign level = level_q;

endmodule

// File: rtl/hdlc_txq_status.sv
module hdlc_txq_status
    import hdlc_txq_pkg::*;
#(
    parameter int DEPTH  = 32,
    parameter int THRESH = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [$clog2(DEPTH+1)-1:0] level,
    input  logic                       wr_drop,
    input  logic                       rd_drop,
    output logic [1:0]                 code,
    output logic                       ovf,
    output logic                       udf
);

    localparam int LVL_W = $clog2(DEPTH+1);
    localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);
    localparam logic [LVL_W-1:0] THR_LVL  = LVL_W'(THRESH);

    fill_code_e code_c;
    logic       ovf_q, udf_q;

    // empty and full outrank the threshold codes
    always_comb begin
        if (level == '0)
            code_c = FILL_EMPTY;
        else if (level == FULL_LVL)
            code_c = FILL_FULL;
        else if (level >= THR_LVL)
            code_c = FILL_HIGH;
        else
            code_c = FILL_LOW;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ovf_q <= 1'b0;
            udf_q <= 1'b0;
        end else begin
            if (wr_drop)
                ovf_q <= 1'b1;
            if (rd_drop)
                udf_q <= 1'b1;
        end
    end

    assign code = code_c;
    assign ovf  = ovf_q;
    assign udf  = udf_q;

endmodule

// File: rtl/hdlc_txq_top.sv
module hdlc_txq_top #(
    parameter int DATA_W = 8,
    parameter int CTR_W  = 7,
    parameter int DEPTH  = 32,
    parameter int THRESH = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              len_wr,
    input  logic [CTR_W-1:0]  len_val,
    input  logic              cyc_en,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_eop,
    output logic [1:0]        fill_code,
    output logic [CTR_W-1:0]  ctr_val,
    output logic              ovf_flag,
    output logic              udf_flag
);

    localparam int ENT_W = DATA_W + 1;
    localparam int LVL_W = $clog2(DEPTH+1);
    localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

    logic [LVL_W-1:0] level;
    logic             push_ok, pop_ok, tag;
    logic [ENT_W-1:0] entry_out;

    assign push_ok = wr_en && (level != FULL_LVL);
    assign pop_ok  = rd_en && (level != '0);

    hdlc_txq_lenctr #(.CTR_W(CTR_W)) u_ctr (
        .clk      (clk),
        .rst      (rst),
        .load     (len_wr),
        .load_val (len_val),
        .cyc_en   (cyc_en),
        .push_ok  (push_ok),
        .count    (ctr_val),
        .tag      (tag)
    );

    hdlc_txq_store #(.WIDTH(ENT_W), .DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .rst   (rst),
        .push  (push_ok),
        .din   ({tag, wr_data}),
        .pop   (pop_ok),
        .dout  (entry_out),
        .level (level)
    );

    hdlc_txq_status #(.DEPTH(DEPTH), .THRESH(THRESH)) u_stat (
        .clk     (clk),
        .rst     (rst),
        .level   (level),
        .wr_drop (wr_en && !push_ok),
        .rd_drop (rd_en && !pop_ok),
        .code    (fill_code),
        .ovf     (ovf_flag),
        .udf     (udf_flag)
    );

    assign rd_data = entry_out[DATA_W-1:0];
    assign rd_eop  = entry_out[DATA_W];

endmodule

// File: rtl/hdlc_txq_chk.sv
module hdlc_txq_chk #(
    parameter int DATA_W = 8,
    parameter int CTR_W  = 7
) (
    input logic              clk,
    input logic              rst,
    input logic              len_wr,
    input logic [CTR_W-1:0]  len_val,
    input logic              cyc_en,
    input logic              wr_en,
    input logic              rd_en,
    input logic [DATA_W-1:0] rd_data,
    input logic              rd_eop,
    input logic [1:0]        fill_code,
    input logic [CTR_W-1:0]  ctr_val,
    input logic              ovf_flag,
    input logic              udf_flag
);

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (fill_code == 2'b10 && ctr_val == '0 && !ovf_flag && !udf_flag)); // R1

    AST_LOAD: assert property (@(posedge clk) disable iff (rst)
        len_wr |=> ctr_val == $past(len_val)); // R2

    AST_STEP: assert property (@(posedge clk) disable iff (rst)
        (wr_en && fill_code != 2'b00 && !len_wr && ctr_val > CTR_W'(1))
        |=> ctr_val == $past(ctr_val) - CTR_W'(1)); // R3

    AST_STOP_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
        (!cyc_en && !len_wr && ctr_val == '0) |=> ctr_val == '0); // R6

    AST_FILL_LEAVES_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (fill_code == 2'b10 && wr_en && !rd_en) |=> fill_code == 2'b11); // R8

    AST_OVF_SET: assert property (@(posedge clk) disable iff (rst)
        (wr_en && fill_code == 2'b00) |=> ovf_flag); // R9

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        ovf_flag |=> ovf_flag); // R9

    AST_UDF_HOLD: assert property (@(posedge clk) disable iff (rst)
        (rd_en && fill_code == 2'b10) |=> (udf_flag && $stable(rd_data) && $stable(rd_eop))); // R10

    AST_UDF_STICKY: assert property (@(posedge clk) disable iff (rst)
        udf_flag |=> udf_flag); // R10

endmodule

bind hdlc_txq_top hdlc_txq_chk #(.DATA_W(DATA_W), .CTR_W(CTR_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .len_wr    (len_wr),
    .len_val   (len_val),
    .cyc_en    (cyc_en),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .rd_data   (rd_data),
    .rd_eop    (rd_eop),
    .fill_code (fill_code),
    .ctr_val   (ctr_val),
    .ovf_flag  (ovf_flag),
    .udf_flag  (udf_flag)
);

// File: tb/hdlc_txq_top_tb_top.sv
`timescale 1ns/100ps
module hdlc_txq_top_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       len_wr = 1'b0;
    logic [6:0] len_val = '0;
    logic       cyc_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic       rd_eop;
    logic [1:0] fill_code;
    logic [6:0] ctr_val;
    logic       ovf_flag, udf_flag;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;

    logic [8:0] sb_q[$];
    logic       mon_arm = 1'b0;
    logic [8:0] last_rd = '0;

    // bench model of the length counter, from the requirements
    int m_ctr = 0;
    int m_prog = 0;

    always #2.5 clk = ~clk;

    hdlc_txq_top dut_i (
        .clk(clk), .rst(rst), .len_wr(len_wr), .len_val(len_val), .cyc_en(cyc_en),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
        .rd_eop(rd_eop), .fill_code(fill_code), .ctr_val(ctr_val),
        .ovf_flag(ovf_flag), .udf_flag(udf_flag)
    );

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles == 100000) begin
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=done", cycles);
            summary();
            $finish;
        end
    end

    // monitor: an accepted read at a rising edge is compared at the next falling edge
    always @(posedge clk) mon_arm <= rd_en && (sb_q.size() > 0);

    always @(negedge clk) begin
        if (mon_arm) begin
            logic [8:0] exp_e;
            exp_e = sb_q.pop_front();
            check({rd_eop, rd_data} == exp_e, "R7/R4 read order and mark",
                  int'({rd_eop, rd_data}), int'(exp_e));
            last_rd = {rd_eop, rd_data};
        end
    end

    function automatic int fill_exp(input int n);
        if (n == 0) return 2;
        if (n == 32) return 0;
        if (n >= 16) return 1;
        return 3;
    endfunction

    // driver: write one byte, optionally with a length load in the same cycle
    task automatic put(input logic [7:0] d, input bit ld, input int lv);
        bit tagb;
        @(negedge clk);
        wr_en = 1'b1; wr_data = d; len_wr = ld; len_val = 7'(lv);
        if (sb_q.size() < 32) begin
            tagb = (m_ctr == 1);
            sb_q.push_back({tagb, d});
            if (ld) m_ctr = lv;
            else if (m_ctr == 1) m_ctr = cyc_en ? m_prog : 0;
            else if (m_ctr > 1) m_ctr = m_ctr - 1;
        end else if (ld) begin
            m_ctr = lv;
        end
        if (ld) m_prog = lv;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; len_wr = 1'b0;
        check(int'(ctr_val) == m_ctr, "R3/R5/R6/R9/R11 counter", ctr_val, m_ctr);
    endtask

    task automatic load(input int lv);
        @(negedge clk);
        len_wr = 1'b1; len_val = 7'(lv);
        m_ctr = lv; m_prog = lv;
        @(posedge clk);
        @(negedge clk);
        len_wr = 1'b0;
        check(int'(ctr_val) == lv, "R2 load", ctr_val, lv);
    endtask

    task automatic pull();
        @(negedge clk);
        rd_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check(fill_code == 2'b10, "R1 fill", fill_code, 2);
        check(ctr_val == 0 && !ovf_flag && !udf_flag, "R1 ctr/flags",
              {ovf_flag, udf_flag, ctr_val}, 0);

        // R6: single packet of three, then an unmarked byte
        cyc_en = 1'b0;
        load(3);
        put(8'hA1, 0, 0);
        put(8'hA2, 0, 0);
        put(8'hA3, 0, 0);
        put(8'hA4, 0, 0);
        check(fill_code == 2'b11, "R8 low code", fill_code, 3);
        repeat (4) pull();
        @(negedge clk);
        check(fill_code == 2'b10, "R8 empty after drain", fill_code, 2);

        // R5: repeating packets of two
        cyc_en = 1'b1;
        load(2);
        for (int i = 0; i < 15; i++) put(8'(8'h10 + i), 0, 0);
        check(fill_code == 2'b11, "R8 15 entries", fill_code, 3);
        put(8'h1F, 0, 0);
        check(fill_code == 2'b01, "R8 16 entries", fill_code, 1);
        for (int i = 0; i < 15; i++) put(8'(8'h40 + i), 0, 0);
        check(fill_code == 2'b01, "R8 31 entries", fill_code, 1);
        put(8'h5F, 0, 0);
        check(fill_code == 2'b00, "R8 full", fill_code, 0);

        // R9: dropped write
        check(!ovf_flag, "R9 ovf clear before", ovf_flag, 0);
        put(8'hEE, 0, 0);
        check(ovf_flag, "R9 ovf set", ovf_flag, 1);
        check(fill_code == 2'b00, "R9 still full", fill_code, 0);

        for (int i = 0; i < 32; i++) pull();
        @(negedge clk);
        check(fill_code == 2'b10, "R8 empty", fill_code, 2);
        check(ovf_flag, "R9 ovf sticky", ovf_flag, 1);

        // R10: read while empty
        pull();
        check({rd_eop, rd_data} == last_rd, "R10 output held",
              int'({rd_eop, rd_data}), int'(last_rd));
        check(udf_flag, "R10 udf set", udf_flag, 1);
        pull();
        check(udf_flag, "R10 udf sticky", udf_flag, 1);

        // R11: load together with the marked write
        cyc_en = 1'b0;
        load(1);
        put(8'hC1, 1, 5);
        put(8'hC2, 0, 0);
        pull();
        pull();
        @(negedge clk);

        // R1: reset clears flags
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_ctr = 0;
        check(!ovf_flag && !udf_flag && ctr_val == 0 && fill_code == 2'b10,
              "R1 second reset", {ovf_flag, udf_flag, fill_code, ctr_val}, 32'h100);
        check(sb_q.size() == 0, "R7 scoreboard drained", sb_q.size(), 0);

        summary();
        $finish;
    end

endmodule